// File: doc/BRIEF.md
# Overlapping 11011 Serial Pattern Detector

A synchronous Mealy state machine that watches a one-bit serial stream, one bit per clock, and flags each place where the five most recent bits, oldest first, read 1,1,0,1,1. The flag is combinational. It rises in the same cycle in which the fifth bit of a match is on the input, so a consumer sees it before the next clock edge.

Matches may overlap. After a hit, the trailing `11` counts as the start of the next candidate, so `11011011` produces two hits. A synchronous, active-high reset clears any partial match and holds the flag low.

Top module: `pattern_watch`

## Requirements
- R1: While `rst` is 1 at a rising edge, `hit` is 0 and the machine goes to the idle state regardless of `din`. Any partial match held before reset is discarded, so the first 1 after reset counts only as the first bit of a new pattern.
- R2: `hit` is 1 exactly in the cycle where `din`=1 completes the five-bit history 1,1,0,1,1 (oldest first) accumulated since the last reset.
- R3: Overlap: in the stream 1,1,0,1,1,0,1,1, `hit` is 1 on the fifth and on the eighth bit.
- R4: A run of more than two 1s keeps the two-ones progress: in the stream 1,1,1,1,0,1,1, `hit` is 1 only on the seventh bit.
- R5: A 0 arriving after 1,1,0,1 or after 1,1,0 drops all progress, so `hit` stays 0 until a fresh full 1,1,0,1,1 arrives.
- R6: The output is Mealy: with 1,1,0,1 already taken, `hit` follows the current `din` within the same cycle (0 for `din`=0, 1 for `din`=1).
- R7: The input stream 001101101110110 (leftmost bit first) produces the output stream 000000100100010.
- R8: In every cycle, `hit` equals the result of comparing a five-bit shift history of `din` (cleared by reset) with 11011.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, has priority over `din` |
| din | input | 1 | Serial data bit, sampled once per clock |
| hit | output | 1 | Combinational match flag for the current bit |

## Verification
The bench targets the fallback after a hit. A detector that returned to idle after a hit would miss the second match in `11011011`. A run of extra ones is exercised because a machine that left the two-ones state on a 1 would miss the match in `1111011`. Zeros arriving after `110` and `1101` are exercised because a stale fallback there would raise a false hit. Reset applied in the middle of a pattern checks that a leftover partial match cannot complete early.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE    = 3'd0,
    ST_GOT1    = 3'd1,
    ST_GOT11   = 3'd2,
    ST_GOT110  = 3'd3,
    ST_GOT1101 = 3'd4
  } pw_state_t;

  // Next-state rule, including fallback on mismatch and overlap.
  function automatic pw_state_t pw_next(input pw_state_t s, input logic b);
    pw_state_t n;
    unique case (s)
      ST_IDLE:    n = b ? ST_GOT1    : ST_IDLE;
      ST_GOT1:    n = b ? ST_GOT11   : ST_IDLE;
      ST_GOT11:   n = b ? ST_GOT11   : ST_GOT110;
      ST_GOT110:  n = b ? ST_GOT1101 : ST_IDLE;
      ST_GOT1101: n = b ? ST_GOT11   : ST_IDLE;
      default:    n = ST_IDLE;
    endcase
    return n;
  endfunction

  // Mealy output: depends on the held state and the bit now on the input.
  function automatic logic pw_hit(input pw_state_t s, input logic b);
    return (s == ST_GOT1101) && b;
  endfunction
endpackage

// File: rtl/pw_state_reg.sv
module pw_state_reg
  import pw_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  pw_state_t nxt,
  output pw_state_t cur
);
  always_ff @(posedge clk) begin
    if (rst) cur <= ST_IDLE;
    else     cur <= nxt;
  end
endmodule

// File: rtl/pw_next_logic.sv
module pw_next_logic
  import pw_pkg::*;
(
  input  pw_state_t cur,
  input  logic      din,
  output pw_state_t nxt
);
  always_comb nxt = pw_next(cur, din);
endmodule

// File: rtl/pw_out_logic.sv
module pw_out_logic
  import pw_pkg::*;
(
  input  pw_state_t cur,
  input  logic      din,
  input  logic      rst,
  output logic      hit
);
  always_comb hit = !rst && pw_hit(cur, din);
endmodule

// File: rtl/pattern_watch.sv
module pattern_watch
  import pw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic hit
);
  pw_state_t cur_state;
  pw_state_t nxt_state;

  pw_state_reg u_reg (
    .clk (clk),
    .rst (rst),
    .nxt (nxt_state),
    .cur (cur_state)
  );

  pw_next_logic u_next (
    .cur (cur_state),
    .din (din),
    .nxt (nxt_state)
  );

  pw_out_logic u_out (
    .cur (cur_state),
    .din (din),
    .rst (rst),
    .hit (hit)
  );
endmodule

// File: rtl/pattern_watch_chk.sv
module pattern_watch_chk
  import pw_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      din,
  input logic      hit,
  input pw_state_t cur
);
  AST_RST_QUIET: assert property (@(posedge clk) rst |-> !hit); // R1
  AST_RST_IDLE: assert property (@(posedge clk) rst |=> (cur == ST_IDLE)); // R1
  AST_HIT_SOURCE: assert property (@(posedge clk) disable iff (rst) hit |-> (cur == ST_GOT1101)); // R2
  AST_HIT_NEEDS_ONE: assert property (@(posedge clk) disable iff (rst) hit |-> din); // R6
  AST_OVERLAP_KEEP: assert property (@(posedge clk) disable iff (rst) hit |=> (cur == ST_GOT11)); // R3
  AST_ONES_STAY: assert property (@(posedge clk) disable iff (rst) (cur == ST_GOT11 && din) |=> (cur == ST_GOT11)); // R4
  AST_ZERO_DROP: assert property (@(posedge clk) disable iff (rst) ((cur == ST_GOT1101 || cur == ST_GOT110) && !din) |=> (cur == ST_IDLE)); // R5
endmodule

bind pattern_watch pattern_watch_chk u_chk (
  .clk (clk),
  .rst (rst),
  .din (din),
  .hit (hit),
  .cur (cur_state)
);

// File: tb/tb_pattern_watch.sv
module tb_pattern_watch;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic hit;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [3:0] hist = 4'd0;  // previous four bits, newest in bit 0
  int         fill = 0;     // valid bits since reset

  always #4 clk = ~clk;     // 125 MHz

  pattern_watch dut (.clk(clk), .rst(rst), .din(din), .hit(hit));

  // {din, expected hit} for the R7 example stream, first bit first
  localparam logic [1:0] VEC [15] = '{
    2'b00, 2'b00, 2'b10, 2'b10, 2'b00, 2'b10, 2'b11, 2'b00,
    2'b10, 2'b11, 2'b10, 2'b00, 2'b10, 2'b11, 2'b00
  };

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: hit=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one bit, compare against the shift-history model, then advance the model.
  task automatic step(input logic d, input logic r, input string tag);
    logic exp;
    @(negedge clk);
    din = d;
    rst = r;
    #2;
    exp = !r && (fill >= 4) && ({hist, d} == 5'b11011);
    check(tag, hit, exp);
    if (r) begin hist = 4'd0; fill = 0; end
    else   begin hist = {hist[2:0], d}; fill++; end
  endtask

  task automatic feed(input string bits, input string tag);
    for (int i = 0; i < bits.len(); i++) step(bits[i] == "1", 1'b0, tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state, din=1 during reset must not raise hit
    step(1'b1, 1'b1, "R1");
    step(1'b1, 1'b1, "R1");

    // R7: example stream from the table, also compared with the model (R8)
    for (int i = 0; i < 15; i++) begin
      step(VEC[i][1], 1'b0, "R8");
      check("R7", hit, VEC[i][0]);
    end

    // R1: reset in the middle of a partial match discards it
    step(1'b0, 1'b1, "R1");
    feed("1101", "R1");
    step(1'b1, 1'b1, "R1");   // would complete a match without reset
    step(1'b1, 1'b0, "R1");
    check("R1", hit, 1'b0);

    // R2 / R3: overlapping matches
    step(1'b0, 1'b1, "R3");
    feed("11011011", "R3");
    // R4: run of ones
    step(1'b0, 1'b1, "R4");
    feed("1111011", "R4");
    // R5: zero after 1101 and after 110 drops progress
    step(1'b0, 1'b1, "R5");
    feed("11010110011011", "R5");
    // R6: Mealy output follows current din in the 1101 state
    step(1'b0, 1'b1, "R6");
    feed("1101", "R6");
    @(negedge clk); din = 1'b0; #1; check("R6", hit, 1'b0);
    din = 1'b1; #1; check("R6", hit, 1'b1);
    din = 1'b0; #1; check("R6", hit, 1'b0);
    hist = 4'd0; fill = 0;
    step(1'b0, 1'b1, "R2");
    feed("0110110111111011011", "R2");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule